// File: doc/BRIEF.md
# Multi-Channel PWM Generator with XOR Pairing

This block drives a set of PWM pins from a two-level timebase. A high-resolution enable, asserted once per fine time step, feeds a shared prescaler. Every `lr_div_m1 + 1` fine steps the prescaler emits one loop tick. Each channel owns a loop counter that advances on those ticks and runs from zero up to the channel's period count. The channel compares that counter against its duty count and its fine-edge value to form a raw waveform.

Software writes period, duty and fine-edge values at any time through a simple write port. The values land in shadow registers. The channel copies them into its working set only when its counter wraps, so a waveform always finishes its current period under the old settings and starts the next one under the new settings. There is no idle gap between the two.

Channels are grouped into even/odd pairs. A pair can be switched into XOR mode. In that mode the even pin carries the XOR of both raw waveforms, so each channel sets one edge of a pulse, and the fine-edge value lets that pulse be narrower than one loop tick. The odd pin is then driven from a per-pair general-purpose output bit.

Top module: `pwm_xor_array`

## Requirements
- R1: A loop tick occurs once every `lr_div_m1 + 1` cycles in which `hr_en` is high; ratios of 32 and 128 are reachable; while `hr_en` is low no counter moves and no pin changes.
- R2: With period count P and duty count D (1 ≤ D ≤ P) and fine value 0, a channel pin is high for D loop ticks and low for P + 1 − D loop ticks in every period.
- R3: A period write of 0 is stored as 1, the smallest legal period, which gives a period of two loop ticks.
- R4: A duty count of 0 together with a fine value of 0 holds the pin low constantly.
- R5: A duty count greater than the period count holds the pin high constantly.
- R6: Field codes on `wr_sel`: 0 period, 1 duty, 2 fine edge (low DW bits of `wr_data`), 3 pair configuration. A period, duty or fine write raises `upd_pend` for that channel on the next cycle; the shadow values move to the working set, and the flag drops, at the channel's next counter wrap (the write wins if both fall in the same cycle).
- R7: A change of period and duty takes the pin straight from the old waveform to the new one; no high or low run during the change exceeds the longest run of either setting.
- R8: Writes to one channel leave every other channel's waveform unchanged.
- R9: A fine value F extends the high time by F high-resolution steps inside the loop tick where the counter equals the duty count.
- R10: With XOR mode on for pair k, pin 2k is the XOR of the raw waveforms of channels 2k and 2k+1; with it off, pin 2k follows channel 2k alone.
- R11: A pair configuration write to any channel of pair k sets that pair's XOR enable from `wr_data[0]` and its output bit from `wr_data[1]`. With XOR on, pin 2k+1 shows the output bit two cycles after the write. With XOR off, the bit has no effect and pin 2k+1 follows channel 2k+1.
- R12: After reset, every pin is low and no update is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hr_en | input | 1 | High-resolution step enable |
| lr_div_m1 | input | DW | Prescale ratio minus one (fine steps per loop tick minus one) |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_sel | input | 2 | Field selector (see R6) |
| wr_data | input | CW | Write data |
| pwm_pin | output | NCH | Registered PWM pins |
| upd_pend | output | NCH | Per-channel shadow update pending |

## Verification
The hardest state to reach from the ports is a pair whose two loop counters are exactly phase-aligned. The XOR pulse width depends on it, and writes that straddle a wrap leave the channels offset. The bench reaches it by resetting, holding `hr_en` low while it programs both channels of the pair, and then releasing the timebase, so both shadows commit on the same wrap. The glitch-free change is reached by timing the write pair just after a rising edge of the pin, so both fields commit on one wrap. The bench then checks every run length through the change and sweeps period, duty and prescale ratio exhaustively over a small range.

// File: rtl/pwm_xor_pkg.sv
package pwm_xor_pkg;

  // Field selector carried on the write port.
  typedef enum logic [1:0] {
    FLD_PERIOD = 2'd0,
    FLD_DUTY   = 2'd1,
    FLD_FINE   = 2'd2,
    FLD_PAIR   = 2'd3
  } pwm_field_e;

endpackage

// File: rtl/pwm_loop_prescaler.sv
module pwm_loop_prescaler #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hr_en,
  input  logic [DW-1:0] div_m1,
  output logic [DW-1:0] pre_cnt,
  output logic          loop_tick
);

  logic [DW-1:0] pre_q;
  logic [DW-1:0] pre_d;
  logic          at_end;

  assign at_end = (pre_q >= div_m1);

  always_comb begin
    pre_d = pre_q;
    if (hr_en) begin
      if (at_end) pre_d = '0;
      else        pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign pre_cnt   = pre_q;
  assign loop_tick = hr_en && at_end;

  // R1: no fine step, no movement
  p_freeze_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hr_en |=> $stable(pre_q));

  // R1: a tick restarts the fine-step count
  p_tick_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    loop_tick |=> (pre_q == '0));

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop_tick,
  input  logic [DW-1:0] pre_cnt,
  input  logic          wr_per,
  input  logic          wr_duty,
  input  logic          wr_fine,
  input  logic [CW-1:0] wr_val,
  output logic          raw,
  output logic          pend
);

  localparam logic [CW-1:0] PER_MIN = CW'(1);

  logic [CW-1:0] per_sh_q,   per_sh_d;
  logic [CW-1:0] duty_sh_q,  duty_sh_d;
  logic [DW-1:0] fine_sh_q,  fine_sh_d;
  logic [CW-1:0] per_act_q,  per_act_d;
  logic [CW-1:0] duty_act_q, duty_act_d;
  logic [DW-1:0] fine_act_q, fine_act_d;
  logic [CW-1:0] cnt_q,      cnt_d;
  logic          pend_q,     pend_d;
  logic          wrap;
  logic          wr_any;

  assign wr_any = wr_per || wr_duty || wr_fine;
  assign wrap   = loop_tick && (cnt_q == per_act_q);

  // Shadow registers: written at any time.
  always_comb begin
    per_sh_d  = per_sh_q;
    duty_sh_d = duty_sh_q;
    fine_sh_d = fine_sh_q;
    if (wr_per)  per_sh_d  = (wr_val == '0) ? PER_MIN : wr_val;
    if (wr_duty) duty_sh_d = wr_val;
    if (wr_fine) fine_sh_d = wr_val[DW-1:0];
  end

  // Working set and loop counter: change only on ticks, reload at wrap.
  always_comb begin
    per_act_d  = per_act_q;
    duty_act_d = duty_act_q;
    fine_act_d = fine_act_q;
    cnt_d      = cnt_q;
    pend_d     = pend_q;
    if (wrap) begin
      cnt_d      = '0;
      per_act_d  = per_sh_q;
      duty_act_d = duty_sh_q;
      fine_act_d = fine_sh_q;
      pend_d     = 1'b0;
    end else if (loop_tick) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (wr_any) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q   <= PER_MIN;
      duty_sh_q  <= '0;
      fine_sh_q  <= '0;
      per_act_q  <= PER_MIN;
      duty_act_q <= '0;
      fine_act_q <= '0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
    end else begin
      per_sh_q   <= per_sh_d;
      duty_sh_q  <= duty_sh_d;
      fine_sh_q  <= fine_sh_d;
      per_act_q  <= per_act_d;
      duty_act_q <= duty_act_d;
      fine_act_q <= fine_act_d;
      cnt_q      <= cnt_d;
      pend_q     <= pend_d;
    end
  end

  // High below the duty count, plus a fine-step tail inside the duty tick.
  assign raw  = (cnt_q < duty_act_q) ||
                ((cnt_q == duty_act_q) && (pre_cnt < fine_act_q));
  assign pend = pend_q;

  // R2: counter never passes the working period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_act_q);

  // R3: working period is never zero
  p_min_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per_act_q != '0);

  // R4: zero duty and zero fine keep the raw waveform low
  p_quiet_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act_q == '0 && fine_act_q == '0) |-> !raw);

  // R5: duty above period keeps the raw waveform high
  p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act_q > per_act_q) |-> raw);

  // R6: working set holds between wraps
  p_hold_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(per_act_q) && $stable(duty_act_q) && $stable(fine_act_q)));

  // R6: a write raises the pending flag
  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> pend_q);

  // R6: a wrap without a write drops the pending flag
  p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_any) |=> !pend_q);

endmodule

// File: rtl/pwm_pair_route.sv
module pwm_pair_route (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_val,
  input  logic       raw_even,
  input  logic       raw_odd,
  output logic       pin_even,
  output logic       pin_odd
);

  logic xor_q, xor_d;
  logic gpo_q, gpo_d;
  logic even_q, even_d;
  logic odd_q,  odd_d;

  always_comb begin
    xor_d = xor_q;
    gpo_d = gpo_q;
    if (cfg_wr) begin
      xor_d = cfg_val[0];
      gpo_d = cfg_val[1];
    end
  end

  always_comb begin
    if (xor_q) begin
      even_d = raw_even ^ raw_odd;
      odd_d  = gpo_q;
    end else begin
      even_d = raw_even;
      odd_d  = raw_odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xor_q  <= 1'b0;
      gpo_q  <= 1'b0;
      even_q <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      xor_q  <= xor_d;
      gpo_q  <= gpo_d;
      even_q <= even_d;
      odd_q  <= odd_d;
    end
  end

  assign pin_even = even_q;
  assign pin_odd  = odd_q;

  // R11: odd pin follows the output bit while paired
  p_odd_gpo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xor_q |=> (pin_odd == $past(gpo_q)));

  // R10: even pin carries the combined edges while paired
  p_even_xor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xor_q |=> (pin_even == $past(raw_even ^ raw_odd)));

  // R10: even pin follows its own channel when unpaired
  p_even_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !xor_q |=> (pin_even == $past(raw_even)));

endmodule

// File: rtl/pwm_xor_array.sv
module pwm_xor_array
  import pwm_xor_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int DW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hr_en,
  input  logic [DW-1:0]  lr_div_m1,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [1:0]     wr_sel,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_pin,
  output logic [NCH-1:0] upd_pend
);

  localparam int NPAIR = NCH / 2;

  initial begin
    assert (NCH >= 2 && (NCH % 2) == 0 && CW >= DW)
      else $error("pwm_xor_array: NCH must be even and CW >= DW");
  end

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  pwm_field_e    fld;
  logic [DW-1:0] pre_cnt;
  logic          loop_tick;
  logic [NCH-1:0] raw_vec;

  assign fld = pwm_field_e'(wr_sel);

  pwm_loop_prescaler #(.DW(DW)) u_prescale (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .hr_en     (hr_en),
    .div_m1    (lr_div_m1),
    .pre_cnt   (pre_cnt),
    .loop_tick (loop_tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = wr_en && (int'(wr_ch) == g);

    pwm_chan_core #(.CW(CW), .DW(DW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .loop_tick (loop_tick),
      .pre_cnt   (pre_cnt),
      .wr_per    (hit && (fld == FLD_PERIOD)),
      .wr_duty   (hit && (fld == FLD_DUTY)),
      .wr_fine   (hit && (fld == FLD_FINE)),
      .wr_val    (wr_data),
      .raw       (raw_vec[g]),
      .pend      (upd_pend[g])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic cfg_hit;
    assign cfg_hit = wr_en && (fld == FLD_PAIR) && ((int'(wr_ch) >> 1) == p);

    pwm_pair_route u_route (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .cfg_wr   (cfg_hit),
      .cfg_val  (wr_data[1:0]),
      .raw_even (raw_vec[2*p]),
      .raw_odd  (raw_vec[2*p+1]),
      .pin_even (pwm_pin[2*p]),
      .pin_odd  (pwm_pin[2*p+1])
    );
  end

  // R12: nothing pending and all pins low in the cycle after reset release
  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$past(rst_core_n) |-> (pwm_pin == '0 && upd_pend == '0));

endmodule

// File: tb/test_pwm_xor_array.sv
module test_pwm_xor_array;

  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int DW  = 8;
  localparam int CHW = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           hr_en;
  logic           hr_drv;
  logic           hr_half;
  logic           hr_tog;
  logic [DW-1:0]  lr_div_m1;
  logic           wr_en;
  logic [CHW-1:0] wr_ch;
  logic [1:0]     wr_sel;
  logic [CW-1:0]  wr_data;
  logic [NCH-1:0] pwm_pin;
  logic [NCH-1:0] upd_pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  always @(negedge clk) hr_tog <= ~hr_tog;
  assign hr_en = hr_half ? hr_tog : hr_drv;

  pwm_xor_array #(.NCH(NCH), .CW(CW), .DW(DW)) i_pwm_xor_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .hr_en     (hr_en),
    .lr_div_m1 (lr_div_m1),
    .wr_en     (wr_en),
    .wr_ch     (wr_ch),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .pwm_pin   (pwm_pin),
    .upd_pend  (upd_pend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = CHW'(ch); wr_sel = 2'(sel); wr_data = CW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // period and duty on consecutive cycles
  task automatic wr_pd(input int ch, input int per, input int duty);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = CHW'(ch); wr_sel = 2'd0; wr_data = CW'(per);
    @(negedge clk);
    wr_sel = 2'd1; wr_data = CW'(duty);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pend(input int ch);
    int g = 0;
    while (upd_pend[ch] && g < 20000) begin @(negedge clk); g++; end
    chk(!upd_pend[ch], "R6 pending flag clears at wrap", int'(upd_pend[ch]), 0);
  endtask

  task automatic measure(input int ch, input int hi, input int lo, input int nper,
                         input string req);
    int g;
    int h;
    int l;
    g = 0; while (pwm_pin[ch] !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
    g = 0; while (pwm_pin[ch] !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
    for (int k = 0; k < nper; k++) begin
      h = 0; while (pwm_pin[ch] === 1'b1 && h < 5000) begin @(negedge clk); h++; end
      l = 0; while (pwm_pin[ch] === 1'b0 && l < 5000) begin @(negedge clk); l++; end
      chk(h == hi, {req, " high time"}, h, hi);
      chk(l == lo, {req, " low time"}, l, lo);
    end
  endtask

  task automatic hold(input int ch, input bit val, input int n, input string req);
    int bad = 0;
    int seen = int'(val);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_pin[ch] !== val) begin bad++; seen = int'(pwm_pin[ch]); end
    end
    chk(bad == 0, req, seen, int'(val));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int mhi;
    int mlo;
    int run;
    bit last;
    hr_tog = 1'b0; hr_half = 1'b0; hr_drv = 1'b0;
    lr_div_m1 = '0; wr_en = 1'b0; wr_ch = '0; wr_sel = '0; wr_data = '0;
    do_reset();

    // R12: reset state
    chk(pwm_pin == '0, "R12 pins low after reset", int'(pwm_pin), 0);
    chk(upd_pend == '0, "R12 nothing pending after reset", int'(upd_pend), 0);

    // R1: ratios 32 and 128
    hr_drv = 1'b1;
    lr_div_m1 = 8'd31;
    wr_pd(0, 1, 1); wait_pend(0);
    measure(0, 32, 32, 1, "R1 ratio 32");
    hr_drv = 1'b0;
    repeat (2) @(negedge clk);
    hold(0, pwm_pin[0], 200, "R1 frozen without hr_en");
    hr_drv = 1'b1;
    lr_div_m1 = 8'd127;
    measure(0, 128, 128, 2, "R1 ratio 128");

    // R1: hr_en every other cycle, ratio 2 -> tick every 4 clocks
    lr_div_m1 = 8'd1;
    hr_half = 1'b1;
    measure(0, 4, 4, 3, "R1 sparse hr_en");
    hr_half = 1'b0;

    // R2 R4 R5: sweep ratio, period and duty
    for (int r = 2; r <= 4; r++) begin
      lr_div_m1 = DW'(r - 1);
      for (int p = 1; p <= 4; p++) begin
        for (int d = 0; d <= p + 2; d++) begin
          wr_pd(0, p, d); wait_pend(0);
          if (d == 0) begin
            repeat (3) @(negedge clk);
            hold(0, 1'b0, 3 * r * (p + 1), "R4 zero duty stays low");
          end else if (d > p) begin
            repeat (3) @(negedge clk);
            hold(0, 1'b1, 3 * r * (p + 1), "R5 duty above period stays high");
          end else begin
            measure(0, r * d, r * (p + 1 - d), 1, "R2 period and duty");
          end
        end
      end
    end

    // R3: period 0 behaves as 1
    lr_div_m1 = 8'd1;
    wr_pd(0, 0, 1); wait_pend(0);
    measure(0, 2, 2, 2, "R3 zero period clamped");

    // R9: fine edge extension, ratio 4, period 3
    lr_div_m1 = 8'd3;
    wr_pd(0, 3, 1); wr(0, 2, 2); wait_pend(0);
    measure(0, 6, 10, 2, "R9 fine tail of two steps");
    wr_pd(0, 3, 0); wr(0, 2, 1); wait_pend(0);
    measure(0, 1, 15, 2, "R9 fine-only pulse");
    wr(0, 2, 0); wait_pend(0);

    // R6 R7: glitch-free change at ratio 2
    lr_div_m1 = 8'd1;
    wr_pd(0, 3, 1); wait_pend(0);
    measure(0, 2, 6, 1, "R7 old setting");
    // pin just rose: counter at start of period, far from wrap
    wr_pd(0, 7, 6);
    chk(upd_pend[0] == 1'b1, "R6 pending after write", int'(upd_pend[0]), 1);
    mhi = 0; mlo = 0; run = 0; last = pwm_pin[0];
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (pwm_pin[0] === last) run++;
      else begin
        if (last) mhi = (run > mhi) ? run : mhi; else mlo = (run > mlo) ? run : mlo;
        run = 1; last = pwm_pin[0];
      end
    end
    chk(mhi <= 12, "R7 no stretched high run", mhi, 12);
    chk(mlo <= 6, "R7 no idle low gap", mlo, 6);
    chk(upd_pend[0] == 1'b0, "R6 applied at wrap", int'(upd_pend[0]), 0);
    measure(0, 12, 4, 1, "R7 new setting");

    // R8: channel 1 undisturbed while channel 0 is rewritten
    wr_pd(1, 4, 2); wait_pend(1);
    fork
      measure(1, 4, 6, 4, "R8 neighbour unchanged");
      begin
        wr_pd(0, 2, 1); wr_pd(0, 5, 3); wr(0, 2, 1); wr_pd(0, 1, 0);
      end
    join

    // R10: aligned pair in XOR mode
    do_reset();
    hr_drv = 1'b0;
    lr_div_m1 = 8'd3;
    wr_pd(0, 3, 2); wr(0, 2, 1);
    wr_pd(1, 3, 2);
    wr(1, 3, 1);
    hr_drv = 1'b1;
    wait_pend(0); wait_pend(1);
    measure(0, 1, 15, 3, "R10 pulse narrower than a loop tick");
    wr(0, 2, 0); wr(0, 1, 3); wr(1, 1, 1);
    wait_pend(0); wait_pend(1);
    measure(0, 8, 8, 2, "R10 two-tick XOR pulse");

    // R11: odd pin as general output
    wr(0, 3, 3);
    @(negedge clk);
    chk(pwm_pin[1] == 1'b1, "R11 output bit high", int'(pwm_pin[1]), 1);
    hold(1, 1'b1, 40, "R11 output bit held");
    wr(1, 3, 1);
    @(negedge clk);
    chk(pwm_pin[1] == 1'b0, "R11 output bit low", int'(pwm_pin[1]), 0);
    wr(0, 3, 2);
    measure(1, 4, 12, 2, "R11 output bit ignored when unpaired");
    measure(0, 12, 4, 2, "R10 even pin alone when unpaired");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule